// File: doc/BRIEF.md
# Memory Base Address Register

This block holds the base address register of one memory resource in a configuration space. It takes dword writes and gives dword reads. A one-bit index picks the lower register (0) or the upper register (1). When the parameter `BAR_64` is set, the two registers together form one 64-bit base address. When it is clear, only the lower register exists. The size of the decoded window is a power of two, set by `SIZE_LOG2`.

Reads return what the register holds. The read-only fields are forced:
- Bit 0 is the memory-space indicator.
- Bits 2:1 give the width encoding.
- Bit 3 gives the prefetch flag.
- Address bits below the window size are always zero.

Sizing gets no special treatment. Writing all ones simply sets every writable bit, so the next read shows the size mask. Because of this, any order of writes works, including sizing one half of a 64-bit register at a time.

The block also outputs the decoded base address and an address-hit flag for the downstream decoder. The hit flag is gated by a decode-enable input. Decoding must be kept off while sizing, because the all-ones pattern moves the base to the top of the address space. `SIZE_LOG2` must lie between 4 and 31 for a 32-bit register, or between 4 and 63 for a 64-bit register.

Top module: `memb_bar`

## Requirements
- R1: After reset, all address bits are zero. The lower register reads as its fixed type nibble only, and the upper register reads as zero.
- R2: A write to index 0 stores data bits 31:4 as address bits 31:4. Bit 0 of the lower register always reads 0, which means memory space.
- R3: Bits 2:1 of the lower register read 2'b10 when `BAR_64` is set and 2'b00 when it is clear, whatever was written.
- R4: Bit 3 of the lower register reads the `PREFETCH` parameter, whatever was written.
- R5: Address bits below `SIZE_LOG2` are zero after every write. An all-ones write to index 0 therefore reads back as the size mask with the type nibble.
- R6: With `BAR_64` set, a write to index 1 replaces only address bits 63:32. A write to index 0 leaves bits 63:32 unchanged.
- R7: A read always returns the stored contents. A value written after an all-ones write reads back as that value (masked), whichever half is written first.
- R8: `base_addr` equals the stored address with bits 3:0 zero. Its upper 32 bits are zero when `BAR_64` is clear.
- R9: `addr_hit` is 1 only when `decode_en` is 1 and `req_addr`, with the bits below `SIZE_LOG2` masked off, equals `base_addr`.
- R10: With `BAR_64` clear, writes to index 1 are ignored and index 1 reads as zero.
- R11: Without `wr_en`, the stored address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Dword write strobe |
| reg_idx | input | 1 | Register select: 0 = lower, 1 = upper |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| decode_en | input | 1 | Enables address matching |
| req_addr | input | 64 | Address to match |
| base_addr | output | 64 | Current decoded base address |
| addr_hit | output | 1 | Request falls inside the window |

## Verification
The bench sizes each half on its own and in both orders. It then writes ordinary values after an all-ones write, which catches a design that keys on the sizing pattern or keeps a hidden size value: such a design would return the size mask instead of the stored address. A second instance, 32-bit and not prefetchable, is driven with the same writes. It shows that upper-register writes are dropped and that the type nibble follows the parameters; a design that decodes the width wrongly would leak the upper half or show the wrong bits 2:1. Hit checks use addresses just inside the window and random addresses, with decode enabled and disabled. A mask off by one bit, or a hit that ignores `decode_en`, fails these checks.

// File: rtl/memb_pkg.sv
package memb_pkg;
  typedef enum logic {IDX_LO = 1'b0, IDX_HI = 1'b1} reg_idx_e;

  // read-only nibble of the lower register: {prefetch, width code, mem space}
  function automatic logic [3:0] type_nibble(input bit is64, input bit pref);
    return {pref, (is64 ? 2'b10 : 2'b00), 1'b0};
  endfunction

  // writable address bits of the full 64-bit base
  function automatic logic [63:0] keep_mask(input bit is64, input int unsigned szlog2);
    logic [63:0] m;
    m = ~64'd0 << szlog2;
    if (!is64) m[63:32] = '0;
    return m;
  endfunction
endpackage

// File: rtl/memb_store.sv
module memb_store
  import memb_pkg::*;
#(
  parameter bit          BAR_64    = 1'b1,
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_idx_e    reg_idx,
  input  logic [31:0] wr_data,
  output logic [31:0] lo_q,
  output logic [31:0] hi_q
);
  localparam logic [63:0] KEEP    = keep_mask(BAR_64, SIZE_LOG2);
  localparam logic [31:0] KEEP_LO = KEEP[31:0];
  localparam logic [31:0] KEEP_HI = KEEP[63:32];

  logic        lo_we;
  logic [31:0] lo_d;

  always_comb begin
    lo_we = wr_en && (reg_idx == IDX_LO);
    lo_d  = wr_data & KEEP_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_we) lo_q <= lo_d;
  end

  generate
    if (BAR_64) begin : g_hi
      logic        hi_we;
      logic [31:0] hi_d;
      always_comb begin
        hi_we = wr_en && (reg_idx == IDX_HI);
        hi_d  = wr_data & KEEP_HI;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_we) hi_q <= hi_d;
      end
      // R6: lower write keeps the upper half
      a_r6_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_LO) |=> $stable(hi_q));
    end else begin : g_no_hi
      assign hi_q = '0;
    end
  endgenerate

  // R6: upper write keeps the lower half
  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_HI) |=> $stable(lo_q));
  // R11: no write, no change
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/memb_rdmux.sv
module memb_rdmux
  import memb_pkg::*;
#(
  parameter bit BAR_64   = 1'b1,
  parameter bit PREFETCH = 1'b0
) (
  input  reg_idx_e    reg_idx,
  input  logic [31:0] lo_q,
  input  logic [31:0] hi_q,
  output logic [31:0] rd_data
);
  localparam logic [3:0] NIB = type_nibble(BAR_64, PREFETCH);

  always_comb begin
    if (reg_idx == IDX_LO) rd_data = {lo_q[31:4], NIB};
    else                   rd_data = BAR_64 ? hi_q : '0;
  end
endmodule

// File: rtl/memb_match.sv
module memb_match #(
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic        decode_en,
  input  logic [63:0] req_addr,
  input  logic [63:0] base,
  output logic        hit
);
  localparam logic [63:0] WIN_MASK = ~64'd0 << SIZE_LOG2;

  always_comb hit = decode_en && ((req_addr & WIN_MASK) == base);
endmodule

// File: rtl/memb_bar.sv
module memb_bar
  import memb_pkg::*;
#(
  parameter bit          BAR_64    = 1'b1,
  parameter bit          PREFETCH  = 1'b1,
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        reg_idx,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        decode_en,
  input  logic [63:0] req_addr,
  output logic [63:0] base_addr,
  output logic        addr_hit
);
  localparam logic [63:0] KEEP = keep_mask(BAR_64, SIZE_LOG2);

  reg_idx_e    idx;
  logic [31:0] lo_q;
  logic [31:0] hi_q;

  assign idx       = reg_idx_e'(reg_idx);
  assign base_addr = {hi_q, lo_q[31:4], 4'b0000};

  memb_store #(.BAR_64(BAR_64), .SIZE_LOG2(SIZE_LOG2)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(idx),
    .wr_data(wr_data), .lo_q(lo_q), .hi_q(hi_q));

  memb_rdmux #(.BAR_64(BAR_64), .PREFETCH(PREFETCH)) u_rdmux (
    .reg_idx(idx), .lo_q(lo_q), .hi_q(hi_q), .rd_data(rd_data));

  memb_match #(.SIZE_LOG2(SIZE_LOG2)) u_match (
    .decode_en(decode_en), .req_addr(req_addr), .base(base_addr), .hit(addr_hit));

  // R2: lower write captures the masked address field
  a_r2_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_idx) |=> (base_addr[31:4] == ($past(wr_data[31:4]) & KEEP[31:4])));
  // R5: bits below the window size stay zero
  a_r5_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (base_addr & ~KEEP) == 64'd0);
  // R9: no hit while decoding is off
  a_r9_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en |-> !addr_hit);
  // R2, R3, R4: lower register low nibble is fixed
  a_r3_type_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_idx |-> (rd_data[3:0] == {PREFETCH, BAR_64, 2'b00}));
endmodule

// File: tb/tb_memb_bar.sv
module tb_memb_bar;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        reg_idx = 1'b0;
  logic [31:0] wr_data = '0;
  logic        decode_en = 1'b0;
  logic [63:0] req_addr = '0;
  logic [31:0] rd64, rd32;
  logic [63:0] base64, base32;
  logic        hit64, hit32;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // models
  logic [63:0] m64 = '0;
  logic [31:0] m32 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memb_bar #(.BAR_64(1'b1), .PREFETCH(1'b1), .SIZE_LOG2(12)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data),
    .rd_data(rd64), .decode_en(decode_en), .req_addr(req_addr),
    .base_addr(base64), .addr_hit(hit64));

  memb_bar #(.BAR_64(1'b0), .PREFETCH(1'b0), .SIZE_LOG2(8)) dut32 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data),
    .rd_data(rd32), .decode_en(decode_en), .req_addr(req_addr),
    .base_addr(base32), .addr_hit(hit32));

  function automatic logic [31:0] exp_rd64(input logic idx);
    return idx ? m64[63:32] : (m64[31:0] | 32'hC);
  endfunction
  function automatic logic [31:0] exp_rd32(input logic idx);
    return idx ? 32'h0 : m32;
  endfunction
  function automatic logic exp_hit(input logic en, input logic [63:0] a,
                                   input logic [63:0] b, input int szl);
    return en && ((a & (~64'd0 << szl)) == b);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    if (!idx) begin
      m64[31:0] = d & 32'hFFFF_F000;
      m32       = d & 32'hFFFF_FF00;
    end else begin
      m64[63:32] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_reads(input string req);
    for (int i = 0; i < 2; i++) begin
      reg_idx = i[0];
      #1;
      chk(req, {32'h0, rd64}, {32'h0, exp_rd64(i[0])});
      chk(req, {32'h0, rd32}, {32'h0, exp_rd32(i[0])});
    end
    chk("R8", base64, m64);
    chk("R8", base32, {32'h0, m32});
  endtask

  task automatic check_hit(input logic en, input logic [63:0] a);
    decode_en = en; req_addr = a;
    #1;
    chk("R9", {63'h0, hit64}, {63'h0, exp_hit(en, a, m64, 12)});
    chk("R9", {63'h0, hit32}, {63'h0, exp_hit(en, a, {32'h0, m32}, 8)});
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    reg_idx = 1'b0; #1;
    chk("R1", {32'h0, rd64}, 64'hC);
    chk("R1", {32'h0, rd32}, 64'h0);
    reg_idx = 1'b1; #1;
    chk("R1", {32'h0, rd64}, 64'h0);
    chk("R1", base64, 64'h0);

    // R5: size the lower half alone
    do_write(1'b0, 32'hFFFF_FFFF);
    reg_idx = 1'b0; #1;
    chk("R5", {32'h0, rd64}, 64'hFFFF_F00C);
    chk("R5", {32'h0, rd32}, 64'hFFFF_FF00);
    reg_idx = 1'b1; #1;
    chk("R6", {32'h0, rd64}, 64'h0);
    chk("R10", {32'h0, rd32}, 64'h0);

    // R7: ordinary value after sizing reads as written
    do_write(1'b0, 32'h1234_5678);
    reg_idx = 1'b0; #1;
    chk("R7", {32'h0, rd64}, 64'h1234_500C);
    chk("R3", {62'h0, rd32[2:1]}, 64'h0);
    chk("R4", {63'h0, rd32[3]}, 64'h0);
    chk("R2", {63'h0, rd64[0]}, 64'h0);

    // R6/R7: size upper half, lower stays
    do_write(1'b1, 32'hFFFF_FFFF);
    reg_idx = 1'b1; #1;
    chk("R7", {32'h0, rd64}, 64'hFFFF_FFFF);
    chk("R10", {32'h0, rd32}, 64'h0);
    reg_idx = 1'b0; #1;
    chk("R6", {32'h0, rd64}, 64'h1234_500C);
    do_write(1'b1, 32'h0000_00AB);
    check_reads("R7");

    // R11: idle cycles
    repeat (5) @(negedge clk);
    check_reads("R11");

    // R9: directed hits
    check_hit(1'b1, m64 | 64'hFFF);
    check_hit(1'b0, m64 | 64'h123);
    check_hit(1'b1, m64 + 64'h1000);
    check_hit(1'b1, {32'h0, m32} | 64'hFF);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      logic ix;
      d  = $urandom();
      ix = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
      if ($urandom_range(0, 4) != 0) do_write(ix, d);
      else @(negedge clk);
      check_reads("R7");
      case ($urandom_range(0, 2))
        0: check_hit($urandom_range(0, 1), m64 | {52'h0, 12'($urandom())});
        1: check_hit($urandom_range(0, 1), {32'h0, m32} | {56'h0, 8'($urandom())});
        default: check_hit($urandom_range(0, 1), {$urandom(), $urandom()});
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule